// File: doc/BRIEF.md
# Two-Wire Stuck-Bus Recovery Controller

This block guards a downstream segment of a two-wire serial bus (clock line and data line, I2C-style, at most 400 kHz). It samples both lines through two-flop synchronizers. A timer runs for as long as the two lines are not high together. When the timer reaches its limit, which corresponds to roughly 45 ms and must lie within 35 to 55 ms, the block pulls its active-low fault flag low. The fault clears, and the timer starts again, as soon as both lines are seen high together.

When the recovery strap `rec_en` is high, a timeout also raises a disconnect request toward the connection logic. If the connection enable `conn_en` is high as well, the block runs one recovery attempt. It sends a burst of clock pulses on the downstream clock line, each with equal low and high phases at or below 100 kHz. The burst stops early once the data line is sampled high at the end of a high phase. It also stops after at most 16 pulses. The block then generates a stop condition: it pulls data low while clock is low, releases clock, and finally releases data. With `rec_en` low, a timeout only pulls the fault flag low.

The sequencer states are:
- `ST_IDLE`: waiting for a fault.
- `ST_PULSE_LO`: clock pulled low.
- `ST_PULSE_HI`: clock released.
- `ST_STOP_SETUP`: clock and data both pulled low.
- `ST_STOP_HOLD`: clock released, data still pulled low.
- `ST_STOP_RELEASE`: both lines released.
- `ST_WAIT_CLEAR`: the attempt is over or aborted; waiting for the fault to clear.

The transitions are:
- IDLE to PULSE_LO on fault with both enables high.
- PULSE_LO to PULSE_HI after one half period.
- PULSE_HI to PULSE_LO after one half period, if data is low and the cap has not been reached.
- PULSE_HI to STOP_SETUP after one half period, if data is high or the cap has been reached.
- STOP_SETUP to STOP_HOLD to STOP_RELEASE, each after one half period.
- STOP_RELEASE to WAIT_CLEAR after one half period.
- Any active state to WAIT_CLEAR when either enable drops.
- WAIT_CLEAR to IDLE once the fault has cleared.

Top module: `stuck_bus_recovery`

## Requirements
- R1: After reset, `fault_n` is 1 and `scl_pd`, `sda_pd` and `disc_req` are 0.
- R2: `fault_n` goes to 0 once the synchronized clock and data lines have not been high together for TIMEOUT_CYC clocks. It remains 1 before that.
- R3: `fault_n` returns to 1 when both lines are sampled high together. Any such moment restarts the timer, so two low spells that are each shorter than the limit raise no fault.
- R4: With `rec_en` = 0, a timeout pulls `fault_n` to 0 but leaves `disc_req`, `scl_pd` and `sda_pd` at 0.
- R5: With `rec_en` = 1 and `conn_en` = 1, a timeout starts a burst. Each pulse holds `scl_pd` = 1 for HALF_CYC clocks and then `scl_pd` = 0 for HALF_CYC clocks.
- R6: The burst ends after the pulse in whose high phase the data line is sampled high at the end of the phase.
- R7: The burst never exceeds MAX_PULSES (16) pulses, even when the data line stays low.
- R8: After the burst, a stop is generated: `sda_pd` rises while `scl_pd` = 1, then `scl_pd` falls while `sda_pd` stays 1, then `sda_pd` falls.
- R9: While `conn_en` = 0, no pulses or stop are generated, and dropping it mid-burst releases the clock line from the next clock on. Raising `conn_en` while a fault is pending and the sequencer is idle starts recovery.
- R10: Only one recovery attempt is made per fault. After an attempt ends or is aborted, no new pulses appear until the fault has cleared.
- R11: `disc_req` is 1 whenever a fault is pending with `rec_en` = 1, and throughout every recovery attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled downstream clock line |
| sda_in | input | 1 | Sampled downstream data line |
| rec_en | input | 1 | Recovery strap: allow disconnect, pulses and stop |
| conn_en | input | 1 | Connection enable; gates pulse and stop generation |
| fault_n | output | 1 | Active-low stuck-bus fault flag |
| scl_pd | output | 1 | Pull-down request for the downstream clock line |
| sda_pd | output | 1 | Pull-down request for the downstream data line |
| disc_req | output | 1 | Request to isolate the downstream segment |

## Verification
The hardest behaviour to reach from the ports is the burst that ends early on a particular pulse. To reach it, the bench needs a bus device that holds data low and lets go only after it has seen a chosen number of recovery clocks. The bench models that device on the wired-AND lines: it counts rising edges of `scl_pd` and releases data after the k-th one. A device that never releases data drives the 16-pulse cap and the stop that follows it. A `conn_en` drop timed mid-burst reaches the abort path and the single-attempt rule.

// File: rtl/srec_pkg.sv
package srec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE_LO,
        ST_PULSE_HI,
        ST_STOP_SETUP,
        ST_STOP_HOLD,
        ST_STOP_RELEASE,
        ST_WAIT_CLEAR
    } srec_state_t;
endpackage

// File: rtl/srec_sync.sv
module srec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0] chain [WIDTH];

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '1;
            else        chain[g] <= {chain[g][STAGES-2:0], d_in[g]};
        end
        assign d_out[g] = chain[g][STAGES-1];
    end
endmodule

// File: rtl/srec_stuck_timer.sv
module srec_stuck_timer #(
    parameter int TIMEOUT_CYC = 9_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic stuck
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    logic [TW-1:0] cnt;
    logic          bus_idle;

    assign bus_idle = scl_s && sda_s;
    assign stuck    = (cnt == TW'(TIMEOUT_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (bus_idle)               cnt <= '0;
        else if (cnt != TW'(TIMEOUT_CYC)) cnt <= cnt + 1'b1;
    end

    AST_IDLE_CLEARS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |=> !stuck); // R3
    AST_FAULT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stuck) |-> $past(!bus_idle)); // R2
endmodule

// File: rtl/srec_fsm.sv
module srec_fsm
    import srec_pkg::*;
#(
    parameter int HALF_CYC   = 1000,
    parameter int MAX_PULSES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stuck,
    input  logic sda_s,
    input  logic rec_en,
    input  logic conn_en,
    output logic scl_pd,
    output logic sda_pd,
    output logic disc_req
);
    localparam int HW = $clog2(HALF_CYC + 1);
    localparam int PW = $clog2(MAX_PULSES + 1);

    srec_state_t   state, nxt;
    logic [HW-1:0] hcnt;
    logic [PW-1:0] pulses;
    logic          half_done, active, enabled;

    assign half_done = (hcnt == HW'(HALF_CYC - 1));
    assign enabled   = rec_en && conn_en;
    assign active    = (state != ST_IDLE) && (state != ST_WAIT_CLEAR);

    always_comb begin
        nxt = state;
        if (active && !enabled) begin
            nxt = ST_WAIT_CLEAR;
        end else begin
            unique case (state)
                ST_IDLE:         if (stuck && enabled) nxt = ST_PULSE_LO;
                ST_PULSE_LO:     if (half_done) nxt = ST_PULSE_HI;
                ST_PULSE_HI:     if (half_done)
                                     nxt = (sda_s || pulses == PW'(MAX_PULSES))
                                           ? ST_STOP_SETUP : ST_PULSE_LO;
                ST_STOP_SETUP:   if (half_done) nxt = ST_STOP_HOLD;
                ST_STOP_HOLD:    if (half_done) nxt = ST_STOP_RELEASE;
                ST_STOP_RELEASE: if (half_done) nxt = ST_WAIT_CLEAR;
                ST_WAIT_CLEAR:   if (!stuck) nxt = ST_IDLE;
                default:         nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            hcnt   <= '0;
            pulses <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)    hcnt <= '0;
            else if (!half_done) hcnt <= hcnt + 1'b1;
            if (state == ST_IDLE)
                pulses <= '0;
            else if (state == ST_PULSE_LO && nxt == ST_PULSE_HI)
                pulses <= pulses + 1'b1;
        end
    end

    always_comb begin
        scl_pd   = 1'b0;
        sda_pd   = 1'b0;
        disc_req = stuck && rec_en;
        unique case (state)
            ST_IDLE:         ;
            ST_PULSE_LO:     begin scl_pd = 1'b1; disc_req = 1'b1; end
            ST_PULSE_HI:     disc_req = 1'b1;
            ST_STOP_SETUP:   begin scl_pd = 1'b1; sda_pd = 1'b1; disc_req = 1'b1; end
            ST_STOP_HOLD:    begin sda_pd = 1'b1; disc_req = 1'b1; end
            ST_STOP_RELEASE: disc_req = 1'b1;
            ST_WAIT_CLEAR:   disc_req = 1'b1;
            default:         ;
        endcase
    end

    AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pulses <= PW'(MAX_PULSES)); // R7
    AST_CONN_LOW_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !conn_en |=> !scl_pd); // R9
    AST_REC_LOW_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> (!scl_pd && !sda_pd)); // R4
    AST_STOP_DATA_UNDER_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pd) |-> scl_pd); // R8
    AST_STOP_CLOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pd) |-> !scl_pd); // R8
endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery #(
    parameter int TIMEOUT_CYC = 9_000_000,
    parameter int HALF_CYC    = 1000,
    parameter int MAX_PULSES  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic rec_en,
    input  logic conn_en,
    output logic fault_n,
    output logic scl_pd,
    output logic sda_pd,
    output logic disc_req
);
    logic [1:0] lines_s;
    logic       stuck;

    srec_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out (lines_s)
    );

    srec_stuck_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .stuck (stuck)
    );

    srec_fsm #(.HALF_CYC(HALF_CYC), .MAX_PULSES(MAX_PULSES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stuck    (stuck),
        .sda_s    (lines_s[0]),
        .rec_en   (rec_en),
        .conn_en  (conn_en),
        .scl_pd   (scl_pd),
        .sda_pd   (sda_pd),
        .disc_req (disc_req)
    );

    assign fault_n = !stuck;

    AST_PULL_IMPLIES_DISC: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pd || sda_pd) |-> disc_req); // R11
    AST_FAULT_DISC: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && rec_en) |-> disc_req); // R11
endmodule

// File: tb/test_stuck_bus_recovery.sv
module test_stuck_bus_recovery;
    localparam int TO   = 200;
    localparam int HALF = 8;
    localparam int MAXP = 16;

    localparam int EV_FAULT_ON  = 1;
    localparam int EV_FAULT_OFF = 2;
    localparam int EV_BURST     = 3;
    localparam int EV_STOP      = 4;

    typedef struct { int kind; int val; } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_en = 1'b0, conn_en = 1'b0;
    logic scl_hold = 1'b0, sda_hold = 1'b0;
    int   rel_target = 0;
    int   pulse_seen = 0;
    logic fault_n, scl_pd, sda_pd, disc_req;
    logic scl_line, sda_line;

    int compared = 0, mismatched = 0;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    assign scl_line = ~scl_pd & ~scl_hold;
    assign sda_line = ~sda_pd & ~(sda_hold && (rel_target == 0 || pulse_seen < rel_target));

    stuck_bus_recovery #(.TIMEOUT_CYC(TO), .HALF_CYC(HALF), .MAX_PULSES(MAXP)) i_stuck_bus_recovery (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .rec_en(rec_en), .conn_en(conn_en),
        .fault_n(fault_n), .scl_pd(scl_pd), .sda_pd(sda_pd), .disc_req(disc_req)
    );

    // bus device model: holds data low until it has seen rel_target recovery clocks
    logic dev_prev_scl = 1'b0;
    always @(negedge clk) begin
        if (!sda_hold) pulse_seen <= 0;
        else if (scl_pd && !dev_prev_scl) pulse_seen <= pulse_seen + 1;
        dev_prev_scl <= scl_pd;
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int val);
        item_t it;
        it.kind = kind; it.val = val;
        exp_q.push_back(it);
    endtask

    task automatic observe(input int kind, input int val);
        item_t it;
        compared++;
        if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL event: actual kind %0d val %0d expected none", kind, val);
        end else begin
            it = exp_q.pop_front();
            if (it.kind != kind || it.val != val) begin
                mismatched++;
                $display("FAIL event: actual kind %0d val %0d expected kind %0d val %0d",
                         kind, val, it.kind, it.val);
            end
        end
    endtask

    task automatic drained(input string req);
        check({req, " pending events"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // monitor
    logic m_fault = 1'b1, m_scl = 1'b0, m_sda = 1'b0;
    int   m_pulses = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fault_n !== m_fault) begin
                if (!fault_n) begin observe(EV_FAULT_ON, 0); m_pulses = 0; end
                else observe(EV_FAULT_OFF, 0);
            end
            if (sda_pd && !m_sda) begin
                observe(EV_BURST, m_pulses);
                m_pulses = 0;
            end else if (scl_pd && !m_scl) begin
                m_pulses++;
            end
            if (!sda_pd && m_sda && !scl_pd) observe(EV_STOP, 0);
        end
        m_fault = fault_n; m_scl = scl_pd; m_sda = sda_pd;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        logic seen;
        cyc(3);
        // R1 reset state
        check("R1 fault_n", fault_n, 1);
        check("R1 scl_pd", scl_pd, 0);
        check("R1 sda_pd", sda_pd, 0);
        check("R1 disc_req", disc_req, 0);
        rst_n = 1'b1;
        cyc(5);

        // R2 / R4: clock held low externally, recovery strap off
        rec_en = 1'b0; conn_en = 1'b1;
        push(EV_FAULT_ON, 0); push(EV_FAULT_OFF, 0);
        scl_hold = 1'b1;
        cyc(TO - 10);
        check("R2 before limit", fault_n, 1);
        cyc(20);
        check("R2 after limit", fault_n, 0);
        check("R4 disc_req", disc_req, 0);
        seen = 0;
        for (int i = 0; i < 50; i++) begin cyc(1); if (scl_pd || sda_pd) seen = 1; end
        check("R4 no pull", seen, 0);
        scl_hold = 1'b0;
        cyc(10);
        check("R3 fault clears", fault_n, 1);
        drained("R3");

        // R3 timer restart: two low spells, each shorter than the limit
        sda_hold = 1'b1; cyc(TO - 60);
        sda_hold = 1'b0; cyc(6);
        sda_hold = 1'b1; cyc(TO - 60);
        check("R3 restart no fault", fault_n, 1);
        sda_hold = 1'b0; cyc(10);
        drained("R3 restart");

        // R5 / R6 / R8: device releases data after 3 recovery clocks
        rec_en = 1'b1; conn_en = 1'b1;
        rel_target = 3;
        push(EV_FAULT_ON, 0); push(EV_FAULT_OFF, 0); push(EV_BURST, 3); push(EV_STOP, 0);
        sda_hold = 1'b1;
        while (!scl_pd) cyc(1);
        check("R11 disc during burst", disc_req, 1);
        n = 0; while (scl_pd) begin n++; cyc(1); end
        check("R5 low phase", n, HALF);
        n = 0; while (!scl_pd) begin n++; cyc(1); end
        check("R5 high phase", n, HALF);
        cyc(150);
        drained("R6 R8");
        check("R11 disc after", disc_req, 0);
        sda_hold = 1'b0; rel_target = 0; cyc(5);

        // R7 / R10: device never releases, burst capped then single attempt
        push(EV_FAULT_ON, 0); push(EV_BURST, MAXP); push(EV_STOP, 0);
        sda_hold = 1'b1;
        cyc(TO + 3 + 2 * HALF * MAXP + 4 * HALF);
        check("R7 fault still low", fault_n, 0);
        drained("R7");
        seen = 0;
        for (int i = 0; i < 100; i++) begin cyc(1); if (scl_pd) seen = 1; end
        check("R10 no second burst", seen, 0);
        check("R11 disc held", disc_req, 1);
        push(EV_FAULT_OFF, 0);
        sda_hold = 1'b0; cyc(10);
        drained("R10");

        // R9: connection enable low blocks, raising it starts recovery
        conn_en = 1'b0; rel_target = 2;
        push(EV_FAULT_ON, 0);
        sda_hold = 1'b1;
        cyc(TO + 100);
        check("R9 fault", fault_n, 0);
        check("R9 no clock while off", pulse_seen, 0);
        check("R11 disc while pending", disc_req, 1);
        drained("R9 blocked");
        push(EV_FAULT_OFF, 0); push(EV_BURST, 2); push(EV_STOP, 0);
        conn_en = 1'b1;
        cyc(150);
        drained("R9 start");
        sda_hold = 1'b0; rel_target = 0; cyc(5);

        // R9 / R10: abort mid-burst, re-enable does not restart
        push(EV_FAULT_ON, 0);
        sda_hold = 1'b1;
        while (fault_n) cyc(1);
        cyc(2 * HALF * 2 + 3);
        conn_en = 1'b0;
        cyc(1);
        seen = 0;
        for (int i = 0; i < 60; i++) begin if (scl_pd) seen = 1; cyc(1); end
        check("R9 abort releases clock", seen, 0);
        conn_en = 1'b1;
        seen = 0;
        for (int i = 0; i < 100; i++) begin cyc(1); if (scl_pd) seen = 1; end
        check("R10 no restart after abort", seen, 0);
        push(EV_FAULT_OFF, 0);
        sda_hold = 1'b0; cyc(10);
        drained("R10 abort");
        check("R1 idle again", scl_pd | sda_pd | disc_req, 0);

        finish_run();
    end
endmodule